// File: doc/BRIEF.md
# Package Forced-Idle Enable Controller

This block owns one package-wide 64-bit control word that any of `NUM_LP` logical processors may write. Only the least significant bit carries meaning: it is the package enable for forced idling. When that bit goes from 0 to 1, every processor whose own allow input is high at that moment is driven into a forced-idle state. When the bit goes from 1 to 0, the processors that this block forced are released.

Writes arrive on one request line per processor, each with its own 64-bit data lane. When several processors write in the same cycle, the lowest processor index wins. A capability strap gates whether the enable bit can change at all. A write that sets any bit other than bit 0 is rejected as a whole and flagged with a one-cycle error pulse.

A package-level change is slow to reach the processors. The block models this with a parameterised delay line between the control word and the force/release logic. The control word itself reads back right away, so software sees the new value before the processors act on it.

Top module: `fidle_pkg_ctrl`

## Requirements
- R1: After reset, `rd_data_o` is all zero, `force_idle_o` is all zero and `wr_err_o` is low.
- R2: A write whose bits 63:1 are zero, made while `cap_i` is 1, loads bit 0 into the enable. The enable reads back on `rd_data_o[0]` one cycle later, and `rd_data_o[63:1]` is always zero.
- R3: While `cap_i` is 0, a write with clean reserved bits leaves the enable unchanged and raises no error.
- R4: A write with any of bits 63:1 set is dropped whatever the value of `cap_i`. The enable is left unchanged, and `wr_err_o` is high in the cycle after that write.
- R5: When several `wr_req_i` bits are high in one cycle, only the lowest-index request is used. This covers both the value it loads and its reserved-bit check.
- R6: A 0-to-1 change of the enable sets `force_idle_o` to `allow_i` as sampled at the capture edge. The outputs change exactly `PROP_DLY`+1 clock edges after the edge that updated the enable, and hold their old value one cycle before that.
- R7: A 1-to-0 change of the enable clears all of `force_idle_o` with the same latency as R6. It releases exactly the processors captured at the preceding rising edge.
- R8: Changes of `allow_i` while the enable is 1 do not alter `force_idle_o`. A processor that opts in late is not forced, and one that opts out stays forced until the release.
- R9: A write that loads the value the enable already holds produces no force or release event.
- R10: The enable may be toggled any number of times, including on consecutive cycles. Each rising edge captures a fresh allow mask, and every edge reaches the outputs in order after the R6 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_i | input | 1 | Capability strap; the enable may change only when 1 |
| allow_i | input | NUM_LP | Per-processor opt-in for forced idling |
| wr_req_i | input | NUM_LP | Per-processor write request |
| wr_data_i | input | NUM_LP*64 | Write data; processor i uses bits [64*i +: 64] |
| rd_data_o | output | 64 | Current control word (bit 0 = enable) |
| force_idle_o | output | NUM_LP | Per-processor force-idle command |
| wr_err_o | output | 1 | One-cycle pulse for a rejected reserved-bit write |

## Verification
The hardest state to reach is the one where rising and falling enable edges are both travelling down the delay line at once. In that state the captured allow mask must be replaced in order, one edge at a time. The bench gets there with back-to-back writes on consecutive cycles. It also changes `allow_i` between capture edges, which shows that only the value present at each delayed rising edge is taken. Same-cycle collisions pair a clean and a bad write in both priority orders, so the winner's reserved-bit check decides the outcome.

// File: rtl/fidle_pkg.sv
`timescale 1ns/1ps
package fidle_pkg;

   localparam int unsigned CTL_W  = 64;
   localparam int unsigned EN_BIT = 0;

   typedef logic [CTL_W-1:0] ctl_word_t;

   // true when no bit above the enable bit is set
   function automatic logic rsv_clean(input ctl_word_t w);
      return (w[CTL_W-1:EN_BIT+1] == '0);
   endfunction

endpackage

// File: rtl/fidle_wr_arb.sv
`timescale 1ns/1ps
module fidle_wr_arb
   import fidle_pkg::*;
#(
   parameter int unsigned NUM_LP = 4
) (
   input  logic [NUM_LP-1:0]       req_i,
   input  logic [NUM_LP*CTL_W-1:0] data_i,
   output logic                    sel_vld_o,
   output ctl_word_t               sel_word_o
);

   // walk from the top index down so the lowest requester is applied last
   always_comb begin
      sel_vld_o  = 1'b0;
      sel_word_o = '0;
      for (int i = NUM_LP - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            sel_vld_o  = 1'b1;
            sel_word_o = data_i[i*CTL_W +: CTL_W];
         end
      end
   end

endmodule

// File: rtl/fidle_ctl_reg.sv
`timescale 1ns/1ps
module fidle_ctl_reg
   import fidle_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cap_i,
   input  logic      sel_vld_i,
   input  ctl_word_t sel_word_i,
   output logic      en_o,
   output logic      err_o
);

   logic legal;
   logic upd;

   assign legal = rsv_clean(sel_word_i);
   assign upd   = sel_vld_i && legal && cap_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o  <= 1'b0;
         err_o <= 1'b0;
      end else begin
         if (upd) en_o <= sel_word_i[EN_BIT];
         err_o <= sel_vld_i && !legal;
      end
   end

endmodule

// File: rtl/fidle_prop_dly.sv
`timescale 1ns/1ps
module fidle_prop_dly #(
   parameter int unsigned DEPTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (DEPTH == 0) begin : g_bypass
         assign q_o = d_i;
      end else if (DEPTH == 1) begin : g_single
         logic stage;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage <= 1'b0;
            else        stage <= d_i;
         end
         assign q_o = stage;
      end else begin : g_chain
         logic [DEPTH-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[DEPTH-2:0], d_i};
         end
         assign q_o = sr[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/fidle_mask.sv
`timescale 1ns/1ps
module fidle_mask #(
   parameter int unsigned NUM_LP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_dly_i,
   input  logic [NUM_LP-1:0] allow_i,
   output logic [NUM_LP-1:0] force_o
);

   logic applied;
   logic rise;
   logic fall;

   assign rise = en_dly_i & ~applied;
   assign fall = ~en_dly_i & applied;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         applied <= 1'b0;
         force_o <= '0;
      end else begin
         applied <= en_dly_i;
         if (rise)      force_o <= allow_i;
         else if (fall) force_o <= '0;
      end
   end

endmodule

// File: rtl/fidle_pkg_ctrl.sv
`timescale 1ns/1ps
module fidle_pkg_ctrl
   import fidle_pkg::*;
#(
   parameter int unsigned NUM_LP   = 4,
   parameter int unsigned PROP_DLY = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cap_i,
   input  logic [NUM_LP-1:0]       allow_i,
   input  logic [NUM_LP-1:0]       wr_req_i,
   input  logic [NUM_LP*CTL_W-1:0] wr_data_i,
   output logic [CTL_W-1:0]        rd_data_o,
   output logic [NUM_LP-1:0]       force_idle_o,
   output logic                    wr_err_o
);

   localparam int unsigned MAX_LP  = 64;
   localparam int unsigned MAX_DLY = 4096;

   if (NUM_LP < 1 || NUM_LP > MAX_LP) begin : g_bad_lp
      $error("fidle_pkg_ctrl: NUM_LP out of range");
   end
   if (PROP_DLY > MAX_DLY) begin : g_bad_dly
      $error("fidle_pkg_ctrl: PROP_DLY too large");
   end

   logic      sel_vld;
   ctl_word_t sel_word;
   logic      en_q;
   logic      en_dly;

   fidle_wr_arb #(.NUM_LP(NUM_LP)) u_arb (
      .req_i      (wr_req_i),
      .data_i     (wr_data_i),
      .sel_vld_o  (sel_vld),
      .sel_word_o (sel_word)
   );

   fidle_ctl_reg u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_i      (cap_i),
      .sel_vld_i  (sel_vld),
      .sel_word_i (sel_word),
      .en_o       (en_q),
      .err_o      (wr_err_o)
   );

   fidle_prop_dly #(.DEPTH(PROP_DLY)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (en_q),
      .q_o   (en_dly)
   );

   fidle_mask #(.NUM_LP(NUM_LP)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_dly_i (en_dly),
      .allow_i  (allow_i),
      .force_o  (force_idle_o)
   );

   always_comb begin
      rd_data_o         = '0;
      rd_data_o[EN_BIT] = en_q;
   end

endmodule

// File: rtl/fidle_pkg_ctrl_chk.sv
`timescale 1ns/1ps
module fidle_pkg_ctrl_chk #(
   parameter int unsigned NUM_LP   = 4,
   parameter int unsigned PROP_DLY = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cap_i,
   input logic [63:0]       rd_data_o,
   input logic [NUM_LP-1:0] force_idle_o,
   input logic              wr_err_o
);

   localparam int unsigned CNT_W = 16;
   localparam logic [CNT_W-1:0] OFF_LIM =
      (PROP_DLY + 2 > 16'hFFFF) ? 16'hFFFF : CNT_W'(PROP_DLY + 2);

   logic [CNT_W-1:0] off_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 off_cnt <= '0;
      else if (rd_data_o[0])      off_cnt <= '0;
      else if (off_cnt != '1)     off_cnt <= off_cnt + 1'b1;
   end

   // R2: only the enable bit can ever read back as one
   p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_o[63:1] == '0);

   // R3: without capability the enable holds
   p_nocap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cap_i) |-> rd_data_o[0] == $past(rd_data_o[0]));

   // R4: a rejected write never moves the enable
   p_err_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err_o |-> rd_data_o == $past(rd_data_o));

   // R8: a captured mask is never edited in place
   p_force_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (force_idle_o != '0 && $past(force_idle_o) != '0)
         |-> force_idle_o == $past(force_idle_o));

   // R7: once the enable has been low long enough nobody is forced
   p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (off_cnt >= OFF_LIM) |-> force_idle_o == '0);

endmodule

bind fidle_pkg_ctrl fidle_pkg_ctrl_chk #(
   .NUM_LP   (NUM_LP),
   .PROP_DLY (PROP_DLY)
) u_chk (.*);

// File: tb/fidle_pkg_ctrl_test.sv
`timescale 1ns/1ps
module fidle_pkg_ctrl_test;

   localparam int N   = 4;
   localparam int DLY = 5;
   localparam int W   = 64;

   typedef struct {
      int          due;
      int          kind;   // 0 readback, 1 force vector, 2 error flag
      logic [63:0] exp;
      string       tag;
   } item_t;

   logic           clk   = 1'b0;
   logic           rst_n = 1'b0;
   logic           cap   = 1'b0;
   logic [N-1:0]   allow = '0;
   logic [N-1:0]   req   = '0;
   logic [N*W-1:0] wdata = '0;
   logic [W-1:0]   rd_data;
   logic [N-1:0]   force_idle;
   logic           wr_err;

   int    cyc = 0;
   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;
   item_t q[$];

   logic         m_en = 1'b0;
   logic [N-1:0] m_force = '0;

   fidle_pkg_ctrl #(.NUM_LP(N), .PROP_DLY(DLY)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cap_i        (cap),
      .allow_i      (allow),
      .wr_req_i     (req),
      .wr_data_i    (wdata),
      .rd_data_o    (rd_data),
      .force_idle_o (force_idle),
      .wr_err_o     (wr_err)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic push(input int due, input int kind, input logic [63:0] exp, input string tag);
      item_t it;
      it.due = due; it.kind = kind; it.exp = exp; it.tag = tag;
      q.push_back(it);
   endtask

   // monitor: compare every item that falls due in this cycle
   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
               case (q[i].kind)
                  0:       check(q[i].tag, rd_data, q[i].exp);
                  1:       check(q[i].tag, {60'b0, force_idle}, q[i].exp);
                  default: check(q[i].tag, {63'b0, wr_err}, q[i].exp);
               endcase
               q.delete(i);
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // driver: one write cycle plus the expected results it implies
   task automatic do_wr(input logic [N-1:0] r, input logic [63:0] d0, input logic [63:0] d1,
                        input logic [63:0] d2, input logic [63:0] d3, input string tag);
      logic [63:0] d[N];
      int          win;
      int          c;
      logic        legal;
      logic        nen;
      d = '{d0, d1, d2, d3};
      win = -1;
      for (int i = N - 1; i >= 0; i--) if (r[i]) win = i;
      c = cyc;
      legal = (win < 0) ? 1'b1 : (d[win][63:1] == '0);
      nen = (win >= 0 && legal && cap) ? d[win][0] : m_en;
      req   = r;
      wdata = {d3, d2, d1, d0};
      push(c + 1, 0, {63'b0, nen}, tag);
      push(c + 1, 2, {63'b0, (win >= 0) && !legal}, tag);
      if (nen != m_en) begin
         push(c + DLY + 1, 1, {60'b0, m_force}, {tag, " before latency"});
         m_force = nen ? allow : '0;
      end
      push(c + DLY + 2, 1, {60'b0, m_force}, tag);
      m_en = nen;
      @(negedge clk);
      req   = '0;
      wdata = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 rd_data", rd_data, 64'h0);
      check("R1 force", {60'b0, force_idle}, 64'h0);
      check("R1 err", {63'b0, wr_err}, 64'h0);
      rst_n = 1'b1;
      idle(2);

      // R2 / R6: enable from processor 2, processors 0 and 2 opted in
      cap   = 1'b1;
      allow = 4'b0101;
      do_wr(4'b0100, 64'h0, 64'h0, 64'h1, 64'h0, "R2 R6 set enable");
      idle(DLY + 4);

      // R8: allow changes while forced leave the captured mask alone
      allow = 4'b1010;
      push(cyc + 3, 1, {60'b0, m_force}, "R8 allow change ignored");
      idle(5);

      // R9: rewriting the same value gives no new capture
      do_wr(4'b0010, 64'h0, 64'h1, 64'h0, 64'h0, "R9 same value write");
      idle(DLY + 4);

      // R4: reserved bits set, alone and with the enable bit
      do_wr(4'b1000, 64'h0, 64'h0, 64'h0, 64'h2, "R4 reserved bit 1");
      do_wr(4'b1000, 64'h0, 64'h0, 64'h0, 64'h8000_0000_0000_0000, "R4 reserved top bit");
      idle(3);

      // R7: release by processor 0
      do_wr(4'b0001, 64'h0, 64'h0, 64'h0, 64'h0, "R7 clear enable");
      idle(DLY + 4);

      // R3: no capability, write ignored; reserved check still active
      cap = 1'b0;
      do_wr(4'b0001, 64'h1, 64'h0, 64'h0, 64'h0, "R3 write without capability");
      do_wr(4'b0001, 64'h5, 64'h0, 64'h0, 64'h0, "R3 R4 bad write without capability");
      idle(DLY + 4);
      cap = 1'b1;

      // R5: collisions, lowest index wins
      do_wr(4'b1100, 64'h0, 64'h0, 64'h1, 64'h0, "R5 proc2 over proc3");
      idle(DLY + 4);
      do_wr(4'b1010, 64'h0, 64'h2, 64'h0, 64'h0, "R5 bad winner proc1");
      idle(2);
      do_wr(4'b1001, 64'h0, 64'h0, 64'h0, 64'h4, "R5 clean winner proc0");
      idle(DLY + 4);

      // R10: repeated toggles, then edges on consecutive cycles
      allow = 4'b0011;
      do_wr(4'b0001, 64'h1, 64'h0, 64'h0, 64'h0, "R10 toggle on");
      idle(DLY + 4);
      allow = 4'b1100;
      do_wr(4'b0001, 64'h0, 64'h0, 64'h0, 64'h0, "R10 toggle off");
      do_wr(4'b0001, 64'h1, 64'h0, 64'h0, 64'h0, "R10 back-to-back on");
      do_wr(4'b0001, 64'h0, 64'h0, 64'h0, 64'h0, "R10 back-to-back off");
      do_wr(4'b0001, 64'h1, 64'h0, 64'h0, 64'h0, "R10 back-to-back on again");
      idle(DLY + 4);
      do_wr(4'b0001, 64'h0, 64'h0, 64'h0, 64'h0, "R10 final off");
      idle(DLY + 6);

      if (q.size() != 0) begin
         total++;
         bad++;
         $display("FAIL scoreboard act=%0d exp=0 pending items", q.size());
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule